// File: doc/BRIEF.md
# Change-Detection Interrupt Controller

This block watches a bank of digital input lines (24 by default) and raises a level interrupt when a selected transition occurs on any of them. Every line has its own rising-edge enable bit and its own falling-edge enable bit. These bits sit in byte-wide registers that can be read and written on a simple 8-bit register bus. Two global control bits turn rising detection and falling detection on or off.

A qualifying transition sets a sticky edge flag. A second qualifying transition that arrives while the edge flag is still set also sets a sticky overflow flag. Software acknowledges the flags by writing ones to an acknowledge register. The interrupt output is the master enable combined with the per-flag event enables. A fixed identification register lets software confirm that the block is present.

The inputs are expected to be synchronous to `clk`. Each line is compared with its own value one clock earlier.

Top module: `chg_irq_ctrl`

## Requirements
- R1: After synchronous reset: the status bits are 0, `irq` is low, the control register reads 0x00, and every enable register reads 0x00.
- R2: A read at address 0x06 always returns 0x27. Writes to that address change nothing.
- R3: Rising-enable byte k (k = 0 .. NLINES/8-1) is at address 0x18+k. Its bit j covers line 8k+j. It reads back the value last written.
- R4: Falling-enable byte k is at address 0x20+k, with the same bit layout as the rising bytes. It reads back the value last written.
- R5: A 0-to-1 change on a line whose rising enable is set, while control bit 3 is 1, sets the edge flag (status bit 0). The flag is visible after the clock edge that first samples the new value. A rising change on a line without its rising bit, or with control bit 3 at 0, does not set the flag.
- R6: A 1-to-0 change on a line whose falling enable is set, while control bit 4 is 1, sets the edge flag. Falling changes on other lines, or with control bit 4 at 0, do not set it.
- R7: A qualifying change that occurs while the edge flag is set, and no acknowledge of the edge flag is written in that cycle, sets the overflow flag (status bit 1).
- R8: In a write to address 0x07, bit 3 = 1 clears the edge flag and bit 2 = 1 clears the overflow flag. A bit written as 0 leaves its flag unchanged.
- R9: If an edge-flag acknowledge and a new qualifying change occur in the same cycle, the edge flag stays set and the overflow flag is not set.
- R10: Status bit 2 and `irq` are both 1 exactly when control bit 2 is 1 and either (edge flag and control bit 0) or (overflow flag and control bit 1). Writing 0x00 to the control register drops `irq`.
- R11: The control register at address 0x15 holds bits 4:0 and reads 0 in bits 7:5. Status reads at address 0x14 as {5'b0, pending, overflow, edge}. Unmapped addresses and reads with `bus_rd` low return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lines_in | input | NLINES | Monitored input lines, synchronous to clk |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; qualifies bus_rdata |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| irq | output | 1 | Level interrupt request |
| status_o | output | 3 | {pending, overflow, edge} flags |

## Verification
The detection path is driven from a table of line patterns, each paired with its own enable masks and control values. Some rows fire in the low, middle and top bytes. Others differ from a firing case in only one respect: the wrong edge direction enabled, the global direction bit off, or a change on a line without its enable bit. This separates per-line masking from global gating. Directed cases then cover the back-to-back change that raises overflow, acknowledges that clear one flag and leave the other, a clear that coincides with a fresh edge, and each term of the interrupt mask.

// File: rtl/chg_pkg.sv
package chg_pkg;

    localparam logic [7:0] ADDR_ID   = 8'h06;
    localparam logic [7:0] ADDR_ACK  = 8'h07;
    localparam logic [7:0] ADDR_STAT = 8'h14;
    localparam logic [7:0] ADDR_CTRL = 8'h15;
    localparam logic [7:0] ADDR_RISE = 8'h18;
    localparam logic [7:0] ADDR_FALL = 8'h20;
    localparam logic [7:0] ID_VALUE  = 8'h27;
    localparam int         ACK_EDGE_BIT = 3;
    localparam int         ACK_OVF_BIT  = 2;

    // control register, bit 4 down to bit 0
    typedef struct packed {
        logic fall_on;
        logic rise_on;
        logic master;
        logic ovf_on;
        logic edge_on;
    } ctrl_t;

    // status, bit 2 down to bit 0
    typedef struct packed {
        logic pend;
        logic ovf;
        logic edge_f;
    } stat_t;

    // true when addr falls in [base, base+count)
    function automatic logic in_window(input logic [7:0] addr,
                                       input logic [7:0] base,
                                       input int count);
        return (addr >= base) && (int'(addr) < int'(base) + count);
    endfunction

endpackage

// File: rtl/chg_enable_bank.sv
module chg_enable_bank #(
    parameter int         NBYTES = 3,
    parameter logic [7:0] BASE   = 8'h18
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [7:0]            addr,
    input  logic [7:0]            wdata,
    output logic [NBYTES*8-1:0]   mask
);
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        localparam logic [7:0] MY_ADDR = 8'(int'(BASE) + k);
        always_ff @(posedge clk) begin
            if (rst)
                mask[k*8 +: 8] <= 8'h00;
            else if (wr && addr == MY_ADDR)
                mask[k*8 +: 8] <= wdata;
        end
    end
endmodule

// File: rtl/chg_edge_detect.sv
module chg_edge_detect #(
    parameter int NLINES = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] lines,
    input  logic [NLINES-1:0] rise_mask,
    input  logic [NLINES-1:0] fall_mask,
    input  logic              rise_on,
    input  logic              fall_on,
    output logic              hit
);
    logic [NLINES-1:0] prev_q;

    // during reset the history tracks the lines so no false edge follows
    always_ff @(posedge clk) begin
        prev_q <= lines;
        if (rst) prev_q <= lines;
    end

    logic [NLINES-1:0] rose, fell;
    always_comb begin
        rose = lines & ~prev_q & rise_mask;
        fell = ~lines & prev_q & fall_mask;
        hit  = (rise_on && |rose) || (fall_on && |fell);
    end
endmodule

// File: rtl/chg_flags.sv
module chg_flags
    import chg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hit,
    input  logic  clr_edge,
    input  logic  clr_ovf,
    input  ctrl_t ctrl,
    output stat_t st,
    output logic  irq
);
    logic edge_q, ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            // a new edge beats a simultaneous acknowledge
            edge_q <= hit || (edge_q && !clr_edge);
            ovf_q  <= (hit && edge_q && !clr_edge) || (ovf_q && !clr_ovf);
        end
    end

    always_comb begin
        st.edge_f = edge_q;
        st.ovf    = ovf_q;
        st.pend   = ctrl.master &&
                    ((edge_q && ctrl.edge_on) || (ovf_q && ctrl.ovf_on));
        irq       = st.pend;
    end
endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl
    import chg_pkg::*;
#(
    parameter int NLINES = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] lines_in,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic [2:0]        status_o
);
    localparam int NBYTES = NLINES / 8;
    localparam int IDXW   = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [NLINES-1:0] rise_mask, fall_mask;
    ctrl_t             ctrl_q;
    stat_t             st;
    logic              hit, clr_edge, clr_ovf;

    chg_enable_bank #(.NBYTES(NBYTES), .BASE(ADDR_RISE)) u_rise (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .mask(rise_mask)
    );

    chg_enable_bank #(.NBYTES(NBYTES), .BASE(ADDR_FALL)) u_fall (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .mask(fall_mask)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (bus_wr && bus_addr == ADDR_CTRL)
            ctrl_q <= ctrl_t'(bus_wdata[4:0]);
    end

    assign clr_edge = bus_wr && bus_addr == ADDR_ACK && bus_wdata[ACK_EDGE_BIT];
    assign clr_ovf  = bus_wr && bus_addr == ADDR_ACK && bus_wdata[ACK_OVF_BIT];

    chg_edge_detect #(.NLINES(NLINES)) u_det (
        .clk(clk), .rst(rst), .lines(lines_in),
        .rise_mask(rise_mask), .fall_mask(fall_mask),
        .rise_on(ctrl_q.rise_on), .fall_on(ctrl_q.fall_on), .hit(hit)
    );

    chg_flags u_flags (
        .clk(clk), .rst(rst), .hit(hit), .clr_edge(clr_edge),
        .clr_ovf(clr_ovf), .ctrl(ctrl_q), .st(st), .irq(irq)
    );

    assign status_o = st;

    // read mux
    logic [7:0]      off_r, off_f;
    logic [IDXW-1:0] idx_r, idx_f;
    always_comb begin
        off_r = bus_addr - ADDR_RISE;
        off_f = bus_addr - ADDR_FALL;
        idx_r = off_r[IDXW-1:0];
        idx_f = off_f[IDXW-1:0];
        bus_rdata = 8'h00;
        if (bus_rd) begin
            if (bus_addr == ADDR_ID)
                bus_rdata = ID_VALUE;
            else if (bus_addr == ADDR_STAT)
                bus_rdata = {5'b0, st};
            else if (bus_addr == ADDR_CTRL)
                bus_rdata = {3'b0, ctrl_q};
            else if (in_window(bus_addr, ADDR_RISE, NBYTES))
                bus_rdata = rise_mask[{idx_r, 3'b000} +: 8];
            else if (in_window(bus_addr, ADDR_FALL, NBYTES))
                bus_rdata = fall_mask[{idx_f, 3'b000} +: 8];
        end
    end
endmodule

// File: rtl/chg_irq_sva.sv
module chg_irq_sva
    import chg_pkg::*;
#(
    parameter int NLINES = 24
) (
    input logic              clk,
    input logic              rst,
    input logic [NLINES-1:0] lines_in,
    input logic [7:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              irq,
    input logic [2:0]        status_o
);
    assert_reset_clean_R1: assert property (@(posedge clk)
        rst |=> (status_o == 3'b000 && !irq));

    assert_id_fixed_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_ID) |-> bus_rdata == ID_VALUE);

    assert_edge_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (status_o[0] && !(bus_wr && bus_addr == ADDR_ACK && bus_wdata[ACK_EDGE_BIT]))
        |=> status_o[0]);

    assert_ovf_needs_edge_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[1]) |-> $past(status_o[0]));

    assert_flag_needs_change_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[0]) |-> $past(lines_in) != $past(lines_in, 2));

    assert_ctrl_off_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_CTRL && bus_wdata == 8'h00) |=> !irq);

    assert_irq_has_flag_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status_o[0] || status_o[1]));
endmodule

bind chg_irq_ctrl chg_irq_sva #(.NLINES(NLINES)) u_sva (
    .clk(clk), .rst(rst), .lines_in(lines_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .status_o(status_o)
);

// File: tb/chg_irq_ctrl_tb.sv
module chg_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 24;

    logic          clk = 0;
    logic          rst = 1;
    logic [NL-1:0] lines_in = '0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 0;
    logic          bus_rd = 0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          irq;
    logic [2:0]    status_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chg_irq_ctrl #(.NLINES(NL)) u_dut (
        .clk(clk), .rst(rst), .lines_in(lines_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .status_o(status_o)
    );

    typedef struct packed {
        logic [23:0] base;
        logic [23:0] nxt;
        logic [23:0] rise;
        logic [23:0] fall;
        logic [4:0]  ctrl;
        logic        exp_edge;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{24'h000000, 24'h000001, 24'h000001, 24'h000000, 5'b01000, 1'b1}, // R5 low byte
        '{24'h000000, 24'h000001, 24'h000001, 24'h000000, 5'b00000, 1'b0}, // R5 rise off
        '{24'h800000, 24'h000000, 24'h000000, 24'h800000, 5'b10000, 1'b1}, // R6 top byte
        '{24'h000000, 24'h010000, 24'h000100, 24'h000000, 5'b01000, 1'b0}, // R5 wrong line
        '{24'hFFFFFF, 24'h000000, 24'hFFFFFF, 24'h000000, 5'b11000, 1'b0}, // R6 no fall bits
        '{24'h00FF00, 24'h000F00, 24'h000000, 24'h00F000, 5'b10000, 1'b1}, // R6 mid byte
        '{24'h000000, 24'h000100, 24'h000000, 24'h000100, 5'b11000, 1'b0}  // R5 rise on fall line
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #1 d = bus_rdata;
        bus_rd = 0;
    endtask

    task automatic set_lines(input logic [NL-1:0] v);
        @(negedge clk);
        lines_in = v;
        @(negedge clk);
    endtask

    task automatic write_masks(input logic [23:0] r, input logic [23:0] f);
        for (int k = 0; k < 3; k++) begin
            wr(8'h18 + 8'(k), r[k*8 +: 8]);
            wr(8'h20 + 8'(k), f[k*8 +: 8]);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        check("R1 status", status_o, 3'b000);
        check("R1 irq", irq, 1'b0);
        rd(8'h15, d); check("R1 ctrl", d, 8'h00);
        rd(8'h18, d); check("R1 rise0", d, 8'h00);
        rd(8'h22, d); check("R1 fall2", d, 8'h00);

        // R2 id register
        rd(8'h06, d); check("R2 id", d, 8'h27);
        wr(8'h06, 8'h55);
        rd(8'h06, d); check("R2 id after write", d, 8'h27);

        // R3 / R4 readback per byte
        write_masks(24'hA1B2C3, 24'h5D6E7F);
        rd(8'h18, d); check("R3 rise0", d, 8'hC3);
        rd(8'h1A, d); check("R3 rise2", d, 8'hA1);
        rd(8'h21, d); check("R4 fall1", d, 8'h6E);
        rd(8'h22, d); check("R4 fall2", d, 8'h5D);
        // R11 ctrl readback, unmapped, no strobe
        wr(8'h15, 8'hFF);
        rd(8'h15, d); check("R11 ctrl mask", d, 8'h1F);
        rd(8'h1B, d); check("R11 unmapped", d, 8'h00);
        bus_addr = 8'h06; #1 check("R11 no strobe", bus_rdata, 8'h00);
        wr(8'h15, 8'h00);

        // table of detection vectors (R5, R6)
        for (int i = 0; i < NV; i++) begin
            write_masks(VECS[i].rise, VECS[i].fall);
            wr(8'h15, {3'b0, VECS[i].ctrl});
            set_lines(VECS[i].base);
            wr(8'h07, 8'h0C);
            check("R8 pre-clear", status_o[1:0], 2'b00);
            set_lines(VECS[i].nxt);
            check(VECS[i].fall != 0 ? "R6 vector" : "R5 vector",
                  status_o[0], VECS[i].exp_edge);
        end

        // R7 overflow and R10 interrupt
        wr(8'h15, 8'h00);
        set_lines('0);
        wr(8'h07, 8'h0C);
        write_masks(24'h000003, 24'h000000);
        wr(8'h15, 8'h08);
        set_lines(24'h000001);
        check("R5 first edge", status_o, 3'b001);
        set_lines(24'h000003);
        check("R7 overflow", status_o, 3'b011);
        wr(8'h15, 8'h0B); // no master
        check("R10 no master", irq, 1'b0);
        wr(8'h15, 8'h0D); // master + edge enable
        check("R10 edge irq", irq, 1'b1);
        rd(8'h14, d); check("R11 status read", d, 8'h07);

        // R8 acknowledge granularity
        wr(8'h07, 8'h00);
        check("R8 zero write", status_o[1:0], 2'b11);
        wr(8'h07, 8'h04);
        check("R8 clear ovf only", status_o[1:0], 2'b01);
        wr(8'h15, 8'h0E); // master + ovf enable only
        check("R10 ovf mask", irq, 1'b0);
        wr(8'h07, 8'h08);
        check("R8 clear edge", status_o[1:0], 2'b00);

        // R9 same-cycle ack and new edge
        set_lines('0);
        set_lines(24'h000001);
        check("R9 setup", status_o[0], 1'b1);
        @(negedge clk);
        lines_in = 24'h000003;
        bus_addr = 8'h07; bus_wdata = 8'h08; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
        check("R9 edge kept", status_o[1:0], 2'b01);

        // R10 control write of zero drops irq
        wr(8'h15, 8'h0D);
        check("R10 irq on", irq, 1'b1);
        wr(8'h15, 8'h00);
        check("R10 ctrl zero", irq, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule